// File: doc/BRIEF.md
# Key-Controlled Watchdog Timer

This block is a watchdog timer whose 12-bit down-counter runs on its own low-speed clock. The counter keeps counting even if the bus clock stops. Software talks to it through four bus-side words. The first is a command word that accepts 16-bit key values. The others are a prescaler code, a reload value and a status word. One key arms the watchdog; after that, software cannot disarm it. A second key refreshes the counter from the reload value. A third key opens the prescaler and reload words for writing. If software stops refreshing, the counter reaches zero and the block drives a reset request for a fixed number of watchdog clock cycles.

Commands cross from the bus clock to the watchdog clock with a toggle handshake. The status word shows a command that has been issued and not yet applied. While a command is in flight, the configuration words are frozen. This keeps the values that the watchdog domain samples stable while it uses them.

Address map on `bus_addr`: 0 is the key word (reads 0), 1 is the prescaler code, 2 is the reload value, and 3 is the status word.

Top module: `keyed_wdt`

## Requirements
- R1: Writing 0xCCCC to the key word arms the watchdog, and status bit 1 reads 1 from then on. No later key write disarms it, and a second 0xCCCC has no effect.
- R2: Once armed, the counter starts from 0xFFF. Without a refresh, the reset request rises 4095 × divisor + 1 watchdog cycles after the arm command is applied in the watchdog domain.
- R3: The reset request rises only when the armed counter has reached 0, and it never rises while the watchdog is unarmed.
- R4: After arming, writing 0xAAAA loads the counter from the reload word, so the next timeout comes reload × divisor + 1 cycles after that load. Before arming, 0xAAAA is ignored and status bits 1:0 stay 0.
- R5: A key value other than 0xCCCC, 0xAAAA or 0x5555 changes neither the counter, the configuration words nor the status word.
- R6: The prescaler and reload words accept writes only after 0x5555 has been written to the key word. Any other key write locks them again, and a write while locked leaves the read-back value unchanged.
- R7: The prescaler code sits in bits 2:0. Codes 0 to 6 divide the watchdog clock by 4 << code, and code 7 divides it by 256. The code is sampled each time an arm or refresh command is applied.
- R8: Status bit 0 reads 1 from the bus cycle after an arm or refresh key until the watchdog domain has applied that command. While it is 1, writes to the configuration words are ignored.
- R9: The reset request stays high for RST_HOLD (16) watchdog cycles and then falls. It does not rise again until a system reset.
- R10: After reset the prescaler reads 0, the reload word reads 0xFFF, the status word reads 0 and the reset request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| clk_wd | input | 1 | Independent low-speed watchdog clock |
| rst_n | input | 1 | System reset, asynchronous, active low |
| bus_we | input | 1 | Write strobe for one bus cycle |
| bus_addr | input | 2 | Word select: 0 key, 1 prescaler, 2 reload, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected word, combinational |
| wd_rst_o | output | 1 | Watchdog reset request |

## Verification
A read-back reflects a write from the next bus cycle on, and status bit 0 is already set on that cycle, so the bench reads these right after each write. An arm or refresh command reaches the counter two or three watchdog edges after the bus edge. For that reason the bench checks every timeout against a window: low until divisor × count + 1 watchdog periods after the write, high by divisor × count + 7. The pulse width is measured between bus-clock samples and accepted within one watchdog period of RST_HOLD periods. The bench waits for status bit 0 to clear before it relies on an applied command.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PSC_W     = 3;
  localparam int MAX_SHIFT = 6;
  localparam int PRE_W     = MAX_SHIFT + 2;

  typedef enum logic [1:0] {
    REG_KEY  = 2'd0,
    REG_PSC  = 2'd1,
    REG_RLD  = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  // Terminal value of the prescaler counter for a given code.
  function automatic logic [PRE_W-1:0] psc_limit(input logic [PSC_W-1:0] code);
    int            sh;
    logic [PRE_W:0] span;
    sh   = (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
    span = (PRE_W+1)'(1) << (sh + 2);
    return PRE_W'(span - 1'b1);
  endfunction
endpackage

// File: rtl/wdt_sync_bit.sv
module wdt_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/wdt_bus_regs.sv
module wdt_bus_regs import wdt_pkg::*; #(
  parameter int          CNT_W       = 12,
  parameter int          DATA_W      = 16,
  parameter logic [15:0] KEY_START   = 16'hCCCC,
  parameter logic [15:0] KEY_REFRESH = 16'hAAAA,
  parameter logic [15:0] KEY_UNLOCK  = 16'h5555
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ack_s,
  output logic              req_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic [CNT_W-1:0]  rld_o
);
  logic             unlk_q, unlk_d;
  logic             armed_q, armed_d;
  logic             req_q, req_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [CNT_W-1:0] rld_q, rld_d;
  logic             pend, key_wr, do_arm, do_refr, cfg_ok;

  assign pend = req_q ^ ack_s;

  always_comb begin
    key_wr  = we && (addr == REG_KEY);
    do_arm  = key_wr && (wdata == DATA_W'(KEY_START)) && !armed_q;
    do_refr = key_wr && (wdata == DATA_W'(KEY_REFRESH)) && armed_q && !pend;
    cfg_ok  = unlk_q && !pend;
    unlk_d  = key_wr ? (wdata == DATA_W'(KEY_UNLOCK)) : unlk_q;
    armed_d = armed_q | do_arm;
    req_d   = req_q ^ (do_arm | do_refr);
    psc_d   = (we && addr == REG_PSC && cfg_ok) ? wdata[PSC_W-1:0] : psc_q;
    rld_d   = (we && addr == REG_RLD && cfg_ok) ? wdata[CNT_W-1:0] : rld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlk_q  <= 1'b0;
      armed_q <= 1'b0;
      req_q   <= 1'b0;
      psc_q   <= '0;
      rld_q   <= '1;
    end else begin
      unlk_q  <= unlk_d;
      armed_q <= armed_d;
      req_q   <= req_d;
      psc_q   <= psc_d;
      rld_q   <= rld_d;
    end
  end

  always_comb begin
    case (addr)
      REG_PSC:  rdata = DATA_W'(psc_q);
      REG_RLD:  rdata = DATA_W'(rld_q);
      REG_STAT: rdata = DATA_W'({armed_q, pend});
      default:  rdata = '0;
    endcase
  end

  assign req_o = req_q;
  assign psc_o = psc_q;
  assign rld_o = rld_q;

  p_arm_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
  p_locked_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr != REG_KEY && !unlk_q) |=> ($stable(psc_q) && $stable(rld_q)));
  p_pend_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr != REG_KEY && pend) |=> ($stable(psc_q) && $stable(rld_q)));
  p_early_refresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wdata == DATA_W'(KEY_REFRESH) && !armed_q) |=> $stable(req_q));
endmodule

// File: rtl/wdt_core.sv
module wdt_core import wdt_pkg::*; #(
  parameter int CNT_W    = 12,
  parameter int RST_HOLD = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_s,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] rld_i,
  output logic             ack_o,
  output logic             wd_rst_o
);
  localparam int HOLD_W = (RST_HOLD > 2) ? $clog2(RST_HOLD) : 1;

  logic             ack_q, ack_d, run_q, run_d, fire_q, fire_d, rst_q, rst_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] pre_q, pre_d, lim_q, lim_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic             evt;

  assign evt = req_s ^ ack_q;

  always_comb begin
    ack_d  = ack_q;
    run_d  = run_q;
    cnt_d  = cnt_q;
    pre_d  = pre_q;
    lim_d  = lim_q;
    fire_d = fire_q;
    rst_d  = rst_q;
    hold_d = hold_q;
    if (evt) begin
      ack_d = req_s;
      run_d = 1'b1;
      lim_d = psc_limit(psc_i);
      pre_d = '0;
      cnt_d = run_q ? rld_i : '1;
    end else if (run_q && !fire_q) begin
      if (pre_q == lim_q) begin
        pre_d = '0;
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
    if (run_q && !fire_q && !evt && cnt_q == '0) begin
      fire_d = 1'b1;
      rst_d  = 1'b1;
      hold_d = HOLD_W'(RST_HOLD - 1);
    end else if (rst_q) begin
      if (hold_q == '0) rst_d = 1'b0;
      else              hold_d = hold_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      run_q  <= 1'b0;
      fire_q <= 1'b0;
      rst_q  <= 1'b0;
      cnt_q  <= '1;
      pre_q  <= '0;
      lim_q  <= '0;
      hold_q <= '0;
    end else begin
      ack_q  <= ack_d;
      run_q  <= run_d;
      fire_q <= fire_d;
      rst_q  <= rst_d;
      cnt_q  <= cnt_d;
      pre_q  <= pre_d;
      lim_q  <= lim_d;
      hold_q <= hold_d;
    end
  end

  assign ack_o    = ack_q;
  assign wd_rst_o = rst_q;

  p_arm_from_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !run_q) |=> (cnt_q == {CNT_W{1'b1}}));
  p_rst_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> run_q);
  p_rise_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> ($past(cnt_q) == '0));
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == '0 && !evt) |=> (cnt_q == '0));
  p_single_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> (fire_q && !$rose(rst_q)));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt import wdt_pkg::*; #(
  parameter int          CNT_W       = 12,
  parameter int          DATA_W      = 16,
  parameter int          RST_HOLD    = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] KEY_START   = 16'hCCCC,
  parameter logic [15:0] KEY_REFRESH = 16'hAAAA,
  parameter logic [15:0] KEY_UNLOCK  = 16'h5555
) (
  input  logic              clk_bus,
  input  logic              clk_wd,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_rst_o
);
  logic rst_bus_n, rst_wd_n;
  logic req_bus, req_wd_s, ack_wd, ack_bus_s;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] rld;

  wdt_sync_bit #(.STAGES(SYNC_STAGES)) u_rsync_bus (
    .clk(clk_bus), .rst_n(rst_n), .d(1'b1), .q(rst_bus_n));
  wdt_sync_bit #(.STAGES(SYNC_STAGES)) u_rsync_wd (
    .clk(clk_wd), .rst_n(rst_n), .d(1'b1), .q(rst_wd_n));
  wdt_sync_bit #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk_wd), .rst_n(rst_wd_n), .d(req_bus), .q(req_wd_s));
  wdt_sync_bit #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk_bus), .rst_n(rst_bus_n), .d(ack_wd), .q(ack_bus_s));

  wdt_bus_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W),
    .KEY_START(KEY_START), .KEY_REFRESH(KEY_REFRESH), .KEY_UNLOCK(KEY_UNLOCK)
  ) u_regs (
    .clk(clk_bus), .rst_n(rst_bus_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .ack_s(ack_bus_s),
    .req_o(req_bus), .psc_o(psc), .rld_o(rld));

  wdt_core #(.CNT_W(CNT_W), .RST_HOLD(RST_HOLD)) u_core (
    .clk(clk_wd), .rst_n(rst_wd_n), .req_s(req_wd_s), .psc_i(psc),
    .rld_i(rld), .ack_o(ack_wd), .wd_rst_o(wd_rst_o));
endmodule

// File: tb/test_keyed_wdt.sv
`timescale 1ns/1ps
module test_keyed_wdt;
  localparam longint TW   = 60;
  localparam int     HOLD = 16;

  logic        clk_bus, clk_wd, rst_n, bus_we;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        wd_rst_o;
  int n_chk = 0, n_err = 0;

  keyed_wdt i_keyed_wdt (.clk_bus(clk_bus), .clk_wd(clk_wd), .rst_n(rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wd_rst_o(wd_rst_o));

  initial clk_bus = 1'b0;
  always #10 clk_bus = ~clk_bus;
  initial clk_wd = 1'b0;
  always #30 clk_wd = ~clk_wd;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sys_reset();
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    repeat (5) @(negedge clk_bus);
    rst_n = 1'b1;
    repeat (20) @(negedge clk_bus);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_bus);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk_bus);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk_bus);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_applied(input string tag);
    logic [15:0] s;
    int n = 0;
    rd(2'd3, s);
    while (s[0] && n < 200) begin rd(2'd3, s); n++; end
    check(!s[0], tag, longint'(s[0]), 0);
  endtask

  task automatic expect_timeout(input longint t0, input longint n, input string tag);
    bit early = 1'b0;
    while ($time < t0 + (n + 1) * TW) begin
      @(negedge clk_bus);
      if (wd_rst_o) early = 1'b1;
    end
    check(!early, tag, ($time - t0) / TW, n + 1);
    while (!wd_rst_o && $time < t0 + (n + 7) * TW) @(negedge clk_bus);
    check(wd_rst_o, tag, ($time - t0) / TW, n + 1);
  endtask

  task automatic t_reset_state();
    logic [15:0] v;
    sys_reset();
    rd(2'd1, v); check(v == 16'd0, "R10 prescaler", v, 0);
    rd(2'd2, v); check(v == 16'hFFF, "R10 reload", v, 16'hFFF);
    rd(2'd3, v); check(v == 16'd0, "R10 status", v, 0);
    check(wd_rst_o == 1'b0, "R10 reset output", wd_rst_o, 0);
  endtask

  task automatic t_lock_and_keys();
    logic [15:0] v;
    sys_reset();
    wr(2'd1, 16'd5);
    rd(2'd1, v); check(v == 16'd0, "R6 locked prescaler write", v, 0);
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd2); wr(2'd2, 16'h123);
    rd(2'd1, v); check(v == 16'd2, "R6 unlocked prescaler", v, 2);
    rd(2'd2, v); check(v == 16'h123, "R6 unlocked reload", v, 16'h123);
    wr(2'd0, 16'h1234);
    rd(2'd3, v); check(v == 16'd0, "R5 stray key status", v, 0);
    rd(2'd2, v); check(v == 16'h123, "R5 stray key reload", v, 16'h123);
    wr(2'd1, 16'd6);
    rd(2'd1, v); check(v == 16'd2, "R6 relocked by other key", v, 2);
    wr(2'd0, 16'hAAAA);
    rd(2'd3, v); check(v == 16'd0, "R4 refresh before arm", v, 0);
    repeat (600) @(negedge clk_bus);
    check(wd_rst_o == 1'b0, "R3 no reset while unarmed", wd_rst_o, 0);
  endtask

  task automatic t_arm_timeout();
    logic [15:0] v;
    longint t0, tr;
    sys_reset();
    wr(2'd0, 16'hCCCC);
    t0 = $time - 10;
    rd(2'd3, v); check(v[0] == 1'b1, "R8 pending after arm", v[0], 1);
    check(v[1] == 1'b1, "R1 armed flag", v[1], 1);
    wr(2'd0, 16'h5555);
    wr(2'd2, 16'h00F);
    wait_applied("R8 arm applied");
    rd(2'd2, v); check(v == 16'hFFF, "R8 write while pending", v, 16'hFFF);
    wr(2'd0, 16'h0000); wr(2'd0, 16'hCCCC); wr(2'd0, 16'h5554);
    rd(2'd3, v); check(v == 16'd2, "R5 stray keys after arm", v, 2);
    expect_timeout(t0, 4095 * 4, "R2 timeout from 0xFFF");
    tr = $time;
    while (wd_rst_o && $time < tr + 4 * HOLD * TW) @(negedge clk_bus);
    check(($time - tr) >= (HOLD - 1) * TW && ($time - tr) <= (HOLD + 1) * TW,
          "R9 pulse width ns", $time - tr, HOLD * TW);
    begin
      bit again = 1'b0;
      repeat (900) begin @(negedge clk_bus); if (wd_rst_o) again = 1'b1; end
      check(!again, "R9 no second pulse", again, 0);
    end
    rd(2'd3, v); check(v[1] == 1'b1, "R1 still armed", v[1], 1);
  endtask

  task automatic t_refresh();
    longint t1;
    sys_reset();
    wr(2'd0, 16'h5555); wr(2'd1, 16'd0); wr(2'd2, 16'd50);
    wr(2'd0, 16'hCCCC);
    wait_applied("R8 arm applied");
    for (int i = 0; i < 20; i++) begin
      repeat (300) @(negedge clk_bus);
      check(wd_rst_o == 1'b0, "R4 refreshed, no reset", wd_rst_o, 0);
      wr(2'd0, 16'hAAAA);
      t1 = $time - 10;
      wait_applied("R8 refresh applied");
    end
    expect_timeout(t1, 50 * 4, "R4 timeout from reload");
  endtask

  task automatic t_prescale(input logic [2:0] code, input int rld, input int div);
    longint t1;
    sys_reset();
    wr(2'd0, 16'h5555); wr(2'd1, 16'(code)); wr(2'd2, 16'(rld));
    wr(2'd0, 16'hCCCC);
    wait_applied("R8 arm applied");
    wr(2'd0, 16'hAAAA);
    t1 = $time - 10;
    expect_timeout(t1, longint'(rld) * div, "R7 prescaler divide");
  endtask

  initial begin
    t_reset_state();
    t_lock_and_keys();
    t_arm_timeout();
    t_refresh();
    t_prescale(3'd3, 10, 32);
    t_prescale(3'd7, 1, 256);
    t_prescale(3'd1, 20, 8);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_bus);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule